// File: doc/BRIEF.md
# Extended/Double Floating-Point Format Converter

This block translates floating-point operands between the 80-bit extended layout (one sign bit, a 15-bit exponent and a 64-bit significand that carries its integer bit explicitly) and the 64-bit double layout (one sign bit, an 11-bit exponent and a 52-bit fraction with a hidden integer bit). A mode input picks the direction for each operand. Narrowing (`to_double` = 1) takes an extended value and produces a double. Widening (`to_double` = 0) takes a double and produces an extended value. The exponent is rebiased between 16383 and 1023, so the offset between them is 15360. Bits that do not fit are dropped by truncation. Denormal inputs are not normalised and NaN payloads get no special care. Infinity, zero and out-of-range exponents are recognised and mapped explicitly.

Each operand enters with `valid_in` and leaves one clock later with `valid_out`. The output register holds its last value while no operand arrives. A two-state machine tracks the output register:

- `ST_EMPTY` holds no fresh result.
- `ST_FULL` presents a result captured on the previous edge.
- Transition *accept*: `valid_in` = 1 moves either state to `ST_FULL`.
- Transition *drain*: `valid_in` = 0 moves either state to `ST_EMPTY`.

Reset enters `ST_EMPTY`. On the data ports, the extended layout uses bit 79 for the sign, bits 78:64 for the exponent and bits 63:0 for the significand. The double layout uses bits 63:0: bit 63 is the sign, bits 62:52 the exponent and bits 51:0 the fraction.

Top module: `ext_dbl_converter`

## Requirements
- R1: Narrowing an extended value with exponent E in 15361..17406 gives sign = bit 79, exponent = E − 15360 and fraction = significand bits 62:11 in `data_out[63:0]`, and `data_out[79:64]` is zero.
- R2: Narrowing the infinity pattern (exponent 0x7FFF, significand 0x8000_0000_0000_0000) gives a double infinity with the input sign: exponent 0x7FF and fraction 0.
- R3: Narrowing an exponent in 17407..0x7FFE (too large for a double) saturates to an infinity with the input sign.
- R4: Narrowing an exponent of 15360 or less, which includes zero, flushes to a zero with the input sign: all bits 62:0 are zero.
- R5: Narrowing exponent 0x7FFF with any other significand gives exponent 0x7FF with fraction = significand bits 62:11.
- R6: Widening a double with exponent X in 1..0x7FE gives sign = bit 63 moved to bit 79, exponent = X + 15360, significand bit 63 set and significand bits 62:11 = fraction. Significand bits 10:0 are zero, and `data_in[79:64]` is ignored.
- R7: Widening a zero (bits 62:0 all zero) gives an all-zero extended value apart from the sign in bit 79.
- R8: Widening exponent 0x7FF gives exponent 0x7FFF, significand bit 63 set and the fraction in bits 62:11.
- R9: Widening a nonzero fraction with exponent 0 gives exponent 15360 with significand bit 63 set and the fraction in bits 62:11 (no normalisation).
- R10: `valid_out` equals `valid_in` delayed by one clock. Reset clears `valid_out` and `data_out` to zero.
- R11: While `valid_in` is low, `data_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operand present this cycle |
| to_double | input | 1 | 1 = extended to double, 0 = double to extended |
| data_in | input | 80 | Operand; a double occupies bits 63:0 |
| valid_out | output | 1 | Result present this cycle |
| data_out | output | 80 | Result; a double occupies bits 63:0 with 79:64 zero |

## Verification
The hardest cases to reach from the ports are the exact edges of the narrowing exponent window. Exponents 15360/15361 and 17406/17407 separate flush, normal and saturate, and a small offset error in the rebias only shows there. The bench drives directed operands at both sides of each edge with constructed significands. It also repeats them with the sign set, so that the sign survives the saturating and flushing paths. A hold scenario changes `data_in` and `to_double` while `valid_in` is low, which shows that the register ignores them.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
    localparam int EXT_EXP_W  = 15;
    localparam int EXT_SIG_W  = 64;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int EXT_W      = 1 + EXT_EXP_W + EXT_SIG_W;
    localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;

    // output register occupancy
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    // operand classes seen by the narrowing path
    typedef enum logic [2:0] {
        NCL_NORM,
        NCL_INF,
        NCL_NAN,
        NCL_OVF,
        NCL_UNF
    } narrow_cls_e;

    // operand classes seen by the widening path
    typedef enum logic [1:0] {
        WCL_NORM,
        WCL_ZERO,
        WCL_SPEC,
        WCL_SUBN
    } widen_cls_e;
endpackage

// File: rtl/fpcvt_narrow.sv
module fpcvt_narrow
    import fpcvt_pkg::*;
#(
    parameter int XE = EXT_EXP_W,
    parameter int XS = EXT_SIG_W,
    parameter int DE = DBL_EXP_W,
    parameter int DF = DBL_FRAC_W
) (
    input  logic [XE+XS:0] ext_i,
    output logic [DE+DF:0] dbl_o
);
    localparam int XBIAS   = 2**(XE-1) - 1;
    localparam int DBIAS   = 2**(DE-1) - 1;
    localparam int REBIAS  = XBIAS - DBIAS;
    localparam int DMAXEXP = 2**DE - 1;
    localparam logic [XE-1:0] REBIAS_X = XE'(REBIAS);
    localparam logic [XE-1:0] OVF_X    = XE'(REBIAS + DMAXEXP);
    localparam logic [XE-1:0] XONES    = '1;
    localparam logic [XS-1:0] INF_SIG  = {1'b1, {(XS-1){1'b0}}};
    localparam logic [DE-1:0] DONES    = '1;

    logic          sgn;
    logic [XE-1:0] exp_x;
    logic [XS-1:0] sig_x;
    logic [DF-1:0] frac_t;
    narrow_cls_e   cls;

    assign sgn    = ext_i[XE+XS];
    assign exp_x  = ext_i[XE+XS-1:XS];
    assign sig_x  = ext_i[XS-1:0];
    // truncating fraction: bits just below the explicit integer bit
    assign frac_t = sig_x[XS-2 -: DF];

    always_comb begin
        if (exp_x == XONES) begin
            cls = (sig_x == INF_SIG) ? NCL_INF : NCL_NAN;
        end else if (exp_x >= OVF_X) begin
            cls = NCL_OVF;
        end else if (exp_x <= REBIAS_X) begin
            cls = NCL_UNF;
        end else begin
            cls = NCL_NORM;
        end
    end

    always_comb begin
        unique case (cls)
            NCL_NORM: dbl_o = {sgn, DE'(exp_x - REBIAS_X), frac_t};
            NCL_NAN:  dbl_o = {sgn, DONES, frac_t};
            NCL_INF,
            NCL_OVF:  dbl_o = {sgn, DONES, {DF{1'b0}}};
            NCL_UNF:  dbl_o = {sgn, {(DE+DF){1'b0}}};
            default:  dbl_o = '0;
        endcase
    end
endmodule

// File: rtl/fpcvt_widen.sv
module fpcvt_widen
    import fpcvt_pkg::*;
#(
    parameter int XE = EXT_EXP_W,
    parameter int XS = EXT_SIG_W,
    parameter int DE = DBL_EXP_W,
    parameter int DF = DBL_FRAC_W
) (
    input  logic [DE+DF:0] dbl_i,
    output logic [XE+XS:0] ext_o
);
    localparam int XBIAS  = 2**(XE-1) - 1;
    localparam int DBIAS  = 2**(DE-1) - 1;
    localparam int PADW   = XS - 1 - DF;
    localparam logic [XE-1:0] REBIAS_X = XE'(XBIAS - DBIAS);
    localparam logic [DE-1:0] DONES    = '1;
    localparam logic [XE-1:0] XONES    = '1;

    logic          sgn;
    logic [DE-1:0] exp_d;
    logic [DF-1:0] frac_d;
    logic [XS-1:0] sig_w;
    widen_cls_e    cls;

    assign sgn    = dbl_i[DE+DF];
    assign exp_d  = dbl_i[DE+DF-1:DF];
    assign frac_d = dbl_i[DF-1:0];
    // explicit integer bit, fraction, zero padding below
    assign sig_w  = {1'b1, frac_d, {PADW{1'b0}}};

    always_comb begin
        if (exp_d == DONES) begin
            cls = WCL_SPEC;
        end else if (exp_d != '0) begin
            cls = WCL_NORM;
        end else if (frac_d == '0) begin
            cls = WCL_ZERO;
        end else begin
            cls = WCL_SUBN;
        end
    end

    always_comb begin
        unique case (cls)
            WCL_NORM: ext_o = {sgn, XE'(exp_d) + REBIAS_X, sig_w};
            WCL_SUBN: ext_o = {sgn, REBIAS_X, sig_w};
            WCL_SPEC: ext_o = {sgn, XONES, sig_w};
            WCL_ZERO: ext_o = {sgn, {(XE+XS){1'b0}}};
            default:  ext_o = '0;
        endcase
    end
endmodule

// File: rtl/ext_dbl_converter.sv
module ext_dbl_converter
    import fpcvt_pkg::*;
#(
    parameter int XE = EXT_EXP_W,
    parameter int XS = EXT_SIG_W,
    parameter int DE = DBL_EXP_W,
    parameter int DF = DBL_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic              to_double,
    input  logic [XE+XS:0]    data_in,
    output logic              valid_out,
    output logic [XE+XS:0]    data_out
);
    localparam int XW = 1 + XE + XS;
    localparam int DW = 1 + DE + DF;

    out_state_e      state_q;
    out_state_e      state_d;
    logic [DW-1:0]   narrow_res;
    logic [XW-1:0]   widen_res;
    logic [XW-1:0]   next_res;
    logic [XW-1:0]   data_q;

    fpcvt_narrow #(.XE(XE), .XS(XS), .DE(DE), .DF(DF)) u_narrow (
        .ext_i (data_in),
        .dbl_o (narrow_res)
    );

    fpcvt_widen #(.XE(XE), .XS(XS), .DE(DE), .DF(DF)) u_widen (
        .dbl_i (data_in[DW-1:0]),
        .ext_o (widen_res)
    );

    assign next_res = to_double ? {{(XW-DW){1'b0}}, narrow_res} : widen_res;

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = valid_in ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = valid_in ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (valid_in) data_q <= next_res;
    end

    assign valid_out = (state_q == ST_FULL);
    assign data_out  = data_q;
endmodule

module fpcvt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic        to_double,
    input logic [79:0] data_in,
    input logic        valid_out,
    input logic [79:0] data_out
);
    // R10: one-cycle valid latency
    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    // R11: result held while idle
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(data_out));
    // R1: a double result leaves the upper field clear
    a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && to_double) |=> (data_out[79:64] == 16'h0));
    // R2: infinity pattern becomes a double infinity
    a_r2_inf_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && to_double && data_in[78:64] == 15'h7FFF &&
         data_in[63:0] == 64'h8000_0000_0000_0000)
        |=> (data_out[62:0] == {11'h7FF, 52'h0} && data_out[63] == $past(data_in[79])));
    // R7: widened zero stays zero apart from the sign
    a_r7_zero_widen: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !to_double && data_in[62:0] == 63'h0)
        |=> (data_out[78:0] == 79'h0 && data_out[79] == $past(data_in[63])));
endmodule

bind ext_dbl_converter fpcvt_checker u_fpcvt_checker (.*);

// File: tb/tb_ext_dbl_converter.sv
module tb_ext_dbl_converter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        to_double = 1'b0;
    logic [79:0] data_in = '0;
    logic        valid_out;
    logic [79:0] data_out;

    int checks = 0;
    int errors = 0;

    ext_dbl_converter dut (
        .clk (clk), .rst_n (rst_n), .valid_in (valid_in), .to_double (to_double),
        .data_in (data_in), .valid_out (valid_out), .data_out (data_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check80(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one operand through the pipe; sampled at the negedge after the capturing edge
    task automatic convert(input string req, input logic mode, input logic [79:0] din,
                           input logic [79:0] exp);
        @(negedge clk);
        valid_in  = 1'b1;
        to_double = mode;
        data_in   = din;
        @(negedge clk);
        valid_in  = 1'b0;
        check1({req, " valid"}, valid_out, 1'b1);
        check80(req, data_out, exp);
    endtask

    task automatic narrow(input string req, input logic [79:0] din, input logic [63:0] exp);
        convert(req, 1'b1, din, {16'h0, exp});
    endtask

    task automatic widen(input string req, input logic [79:0] din, input logic [79:0] exp);
        convert(req, 1'b0, din, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check1("R10 reset valid", valid_out, 1'b0);
        check80("R10 reset data", data_out, 80'h0);
    endtask

    task automatic t_narrow_normal;
        narrow("R1 one", {16'h3FFF, 64'h8000_0000_0000_0000}, 64'h3FF0_0000_0000_0000);
        narrow("R1 neg 2.5", {16'hC000, 64'hA000_0000_0000_0000}, 64'hC004_0000_0000_0000);
        narrow("R1 truncation", {16'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF}, 64'h3FFF_FFFF_FFFF_FFFF);
        narrow("R1 top edge", {16'h43FE, 64'h8000_0000_0000_0000}, 64'h7FE0_0000_0000_0000);
        narrow("R1 bottom edge", {16'h3C01, 64'h8000_0000_0000_0000}, 64'h0010_0000_0000_0000);
    endtask

    task automatic t_narrow_special;
        narrow("R2 +inf", {16'h7FFF, 64'h8000_0000_0000_0000}, 64'h7FF0_0000_0000_0000);
        narrow("R2 -inf", {16'hFFFF, 64'h8000_0000_0000_0000}, 64'hFFF0_0000_0000_0000);
        narrow("R3 overflow edge", {16'h43FF, 64'h8000_0000_0000_0000}, 64'h7FF0_0000_0000_0000);
        narrow("R3 overflow neg", {16'hFFFE, 64'hC000_0000_0000_0000}, 64'hFFF0_0000_0000_0000);
        narrow("R4 underflow edge", {16'hBC00, 64'hFFFF_0000_0000_0000}, 64'h8000_0000_0000_0000);
        narrow("R4 zero", {16'h0000, 64'h0}, 64'h0);
        narrow("R5 nan", {16'h7FFF, 64'hC000_0000_0000_0000}, 64'h7FF8_0000_0000_0000);
    endtask

    task automatic t_widen;
        widen("R6 one", {16'h0, 64'h3FF0_0000_0000_0000}, {16'h3FFF, 64'h8000_0000_0000_0000});
        widen("R6 neg 2.5", {16'h0, 64'hC004_0000_0000_0000}, {16'hC000, 64'hA000_0000_0000_0000});
        widen("R6 upper ignored", {16'hABCD, 64'h3FF0_0000_0000_0000}, {16'h3FFF, 64'h8000_0000_0000_0000});
        widen("R6 max", {16'h0, 64'h7FEF_FFFF_FFFF_FFFF}, {16'h43FE, 64'hFFFF_FFFF_FFFF_F800});
        widen("R7 neg zero", {16'h0, 64'h8000_0000_0000_0000}, {16'h8000, 64'h0});
        widen("R7 pos zero", {16'h1234, 64'h0}, 80'h0);
        widen("R8 -inf", {16'h0, 64'hFFF0_0000_0000_0000}, {16'hFFFF, 64'h8000_0000_0000_0000});
        widen("R9 subnormal", {16'h0, 64'h0000_0000_0000_0001}, {16'h3C00, 64'h8000_0000_0000_0800});
    endtask

    task automatic t_hold;
        narrow("R11 setup", {16'h3FFF, 64'h8000_0000_0000_0000}, 64'h3FF0_0000_0000_0000);
        @(negedge clk);
        to_double = 1'b0;
        data_in   = {16'h0, 64'hC004_0000_0000_0000};
        @(negedge clk);
        check1("R10 idle valid", valid_out, 1'b0);
        check80("R11 hold", data_out, {16'h0, 64'h3FF0_0000_0000_0000});
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        valid_in = 1'b1; to_double = 1'b1; data_in = {16'h4000, 64'h8000_0000_0000_0000};
        @(negedge clk);
        check80("R10 b2b first", data_out, {16'h0, 64'h4000_0000_0000_0000});
        to_double = 1'b0; data_in = {16'h0, 64'h4000_0000_0000_0000};
        @(negedge clk);
        valid_in = 1'b0;
        check1("R10 b2b valid", valid_out, 1'b1);
        check80("R10 b2b second", data_out, {16'h4000, 64'h8000_0000_0000_0000});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_narrow_normal();
        t_narrow_special();
        t_widen();
        t_hold();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule